// File: doc/BRIEF.md
# Parity Error Injection Controller

This block corrupts the parity that travels with outgoing write traffic, so that the error checkers further down the path can be exercised on real transfers. It sits on a set of egress ports. Every port carries beats of four kinds: command headers and data beats, each in a best-effort or an isochronous traffic class. For each port and each of these four kinds there is an enable bit and a done bit, and all of them sit in one 32-bit control/status register that software reads and writes.

When an enabled port/kind pair sees a qualifying beat, the block inverts that beat's parity bit and sets the matching done bit. A separate mode input picks the behaviour. In single-shot mode exactly one beat is corrupted per arming. In persistent mode every qualifying beat is corrupted for as long as the enable bit stays set. To fire again in single-shot mode, software must clear both the enable bit and the done bit and then set the enable bit once more.

The parity path is registered: `parity_out` shows a beat's parity, possibly inverted, one clock after that beat is presented. Parity generation and error checking belong to other blocks.

Top module: `perr_inject_ctrl`

## Requirements
- R1: Synchronous active-high reset clears every register bit, so `csr_rdata` reads 0, and drives every `parity_out` bit to 0.
- R2: A value written through `csr_wr_en`/`csr_wdata` reads back on `csr_rdata` from the next cycle on, as long as no hardware done-set happens in that cycle; all 32 bits are writable.
- R3: For port p and kind index k = 2*(1-iso)+data, where `beat_iso`=1 means isochronous and `beat_data`=1 means data beat, the enable bit sits at k*4+p and the done bit at 16+k*4+p. Kinds 0..3 are isochronous command, isochronous data, best-effort command and best-effort data. A beat qualifies only when `beat_valid` and `beat_ready` of that port are both 1 and its kind matches an enabled bit of that same port. Any other beat passes unchanged.
- R4: `parity_out[p]` equals `parity_in[p]` of the previous cycle, inverted exactly when that beat was corrupted.
- R5: In single-shot mode (`mode_persist`=0), the first qualifying beat after the enable bit goes from 0 to 1 while its done bit is 0 is corrupted, and its done bit reads 1 from the next cycle. This holds even when that beat comes in the cycle right after the enabling write.
- R6: In single-shot mode, no further beat is corrupted until software has cleared both the enable bit and the done bit and then set the enable bit again. Setting the enable bit while the done bit is still 1 does not arm, and clearing only the done bit does not arm.
- R7: In persistent mode (`mode_persist`=1), every qualifying beat is corrupted while its enable bit is 1, and the done bit is set by the first such beat.
- R8: When a done-set and a software write land in the same cycle, the done bit ends up 1 whatever was written there.
- R9: A change of `mode_persist` takes effect on the next qualifying beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr_en | input | 1 | Register write strobe |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register contents |
| mode_persist | input | 1 | 1 = persistent injection, 0 = single-shot |
| beat_valid | input | 4 | Per-port beat valid |
| beat_ready | input | 4 | Per-port beat ready |
| beat_iso | input | 4 | Per-port class tag, 1 = isochronous, 0 = best-effort |
| beat_data | input | 4 | Per-port beat type, 1 = data, 0 = command header |
| parity_in | input | 4 | Per-port incoming parity bit |
| parity_out | output | 4 | Per-port registered, possibly inverted, parity bit |

## Verification
The checker assumes three things about the inputs. `parity_in` holds a defined value during reset. Software never writes the register in the cycle right after a corrupted beat, so a done bit that the checker expects to see is not cleared before it can be observed. A done bit or enable bit changes only through a write or a hardware done-set. The bench keeps to these assumptions: it drives all inputs to 0 during reset, and it issues every register write and every beat as a separate one-cycle step on the falling edge. The one exception is the hardware-wins case, which presents a write and a beat in the same cycle on purpose.

// File: rtl/perr_pkg.sv
package perr_pkg;
  localparam int NUM_KINDS = 4;   // command/data x isochronous/best-effort
  localparam int KIND_W    = 2;

  typedef enum logic [KIND_W-1:0] {
    KIND_ISO_CMD = 2'd0,
    KIND_ISO_DAT = 2'd1,
    KIND_BE_CMD  = 2'd2,
    KIND_BE_DAT  = 2'd3
  } kind_e;

  // kind index from class tag and beat type (R3)
  function automatic kind_e kind_of(input logic iso, input logic data);
    return kind_e'({~iso, data});
  endfunction
endpackage

// File: rtl/perr_csr.sv
module perr_csr #(
  parameter int PAIRS = 16,
  localparam int REG_W = 2 * PAIRS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  input  logic [PAIRS-1:0] hw_done,
  output logic [REG_W-1:0] reg_q
);
  logic [REG_W-1:0] reg_d;

  always_comb begin
    reg_d = wr_en ? wdata : reg_q;
    // hardware completion wins over a concurrent software write
    reg_d[REG_W-1:PAIRS] = reg_d[REG_W-1:PAIRS] | hw_done;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_q <= '0;
    else     reg_q <= reg_d;
  end
endmodule

// File: rtl/perr_arm_cell.sv
module perr_arm_cell (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic done,
  input  logic qualify,
  input  logic persist,
  output logic fire
);
  logic en_prev;
  logic armed;
  logic arm_now;

  // arm on an enable rising edge seen while done is clear
  assign arm_now = armed | (en & ~en_prev & ~done);
  assign fire    = qualify & en & (persist | arm_now);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_prev <= 1'b0;
      armed   <= 1'b0;
    end else begin
      en_prev <= en;
      armed   <= en & arm_now & ~fire;
    end
  end
endmodule

// File: rtl/perr_lane.sv
module perr_lane (
  input  logic clk,
  input  logic rst,
  input  logic par_in,
  input  logic flip,
  output logic par_out
);
  always_ff @(posedge clk) begin
    if (rst) par_out <= 1'b0;
    else     par_out <= par_in ^ flip;
  end
endmodule

// File: rtl/perr_inject_ctrl.sv
module perr_inject_ctrl #(
  parameter int PORTS = 4,
  localparam int PAIRS = PORTS * perr_pkg::NUM_KINDS,
  localparam int REG_W = 2 * PAIRS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             csr_wr_en,
  input  logic [REG_W-1:0] csr_wdata,
  output logic [REG_W-1:0] csr_rdata,
  input  logic             mode_persist,
  input  logic [PORTS-1:0] beat_valid,
  input  logic [PORTS-1:0] beat_ready,
  input  logic [PORTS-1:0] beat_iso,
  input  logic [PORTS-1:0] beat_data,
  input  logic [PORTS-1:0] parity_in,
  output logic [PORTS-1:0] parity_out
);
  import perr_pkg::*;

  logic [REG_W-1:0] reg_q;
  logic [PAIRS-1:0] fire;
  logic [PORTS-1:0] flip;

  perr_csr #(.PAIRS(PAIRS)) u_csr (
    .clk(clk), .rst(rst), .wr_en(csr_wr_en), .wdata(csr_wdata),
    .hw_done(fire), .reg_q(reg_q)
  );

  assign csr_rdata = reg_q;

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
    for (genvar p = 0; p < PORTS; p++) begin : g_port
      localparam int IDX = k * PORTS + p;
      logic qual;
      assign qual = beat_valid[p] & beat_ready[p] &
                    (kind_of(beat_iso[p], beat_data[p]) == kind_e'(k));
      perr_arm_cell u_cell (
        .clk(clk), .rst(rst),
        .en(reg_q[IDX]), .done(reg_q[PAIRS + IDX]),
        .qualify(qual), .persist(mode_persist),
        .fire(fire[IDX])
      );
    end
  end

  always_comb begin
    flip = '0;
    for (int p = 0; p < PORTS; p++)
      for (int k = 0; k < NUM_KINDS; k++)
        flip[p] = flip[p] | fire[k*PORTS + p];
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_lane
    perr_lane u_lane (
      .clk(clk), .rst(rst), .par_in(parity_in[p]),
      .flip(flip[p]), .par_out(parity_out[p])
    );
  end
endmodule

// File: rtl/perr_inject_chk.sv
module perr_inject_chk #(
  parameter int PORTS = 4,
  localparam int PAIRS = PORTS * perr_pkg::NUM_KINDS,
  localparam int REG_W = 2 * PAIRS
) (
  input logic             clk,
  input logic             rst,
  input logic             csr_wr_en,
  input logic [REG_W-1:0] csr_rdata,
  input logic [PORTS-1:0] beat_valid,
  input logic [PORTS-1:0] beat_ready,
  input logic [PORTS-1:0] parity_in,
  input logic [PORTS-1:0] parity_out
);
  logic [PORTS-1:0] port_done;

  always_comb begin
    port_done = '0;
    for (int p = 0; p < PORTS; p++)
      for (int k = 0; k < perr_pkg::NUM_KINDS; k++)
        port_done[p] = port_done[p] | csr_rdata[PAIRS + k*PORTS + p];
  end

  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (csr_rdata == '0 && parity_out == '0)); // R1

  AST_EN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(csr_wr_en)) |->
      csr_rdata[PAIRS-1:0] == $past(csr_rdata[PAIRS-1:0])); // R2

  AST_FLIP_NEEDS_BEAT: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |->
      ((parity_out ^ $past(parity_in)) & ~$past(beat_valid & beat_ready)) == '0); // R3

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(csr_wr_en)) |->
      (csr_rdata[REG_W-1:PAIRS] & $past(csr_rdata[REG_W-1:PAIRS]))
        == $past(csr_rdata[REG_W-1:PAIRS])); // R7

  for (genvar p = 0; p < PORTS; p++) begin : g_p
    AST_FLIP_SETS_DONE: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && (parity_out[p] != $past(parity_in[p]))) |-> port_done[p]); // R8
  end
endmodule

bind perr_inject_ctrl perr_inject_chk #(.PORTS(PORTS)) u_chk (
  .clk(clk), .rst(rst), .csr_wr_en(csr_wr_en), .csr_rdata(csr_rdata),
  .beat_valid(beat_valid), .beat_ready(beat_ready),
  .parity_in(parity_in), .parity_out(parity_out)
);

// File: tb/sim_perr_inject_ctrl.sv
module sim_perr_inject_ctrl;
  localparam int PORTS = 4;
  localparam int REG_W = 32;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             csr_wr_en = 1'b0;
  logic [REG_W-1:0] csr_wdata = '0;
  logic [REG_W-1:0] csr_rdata;
  logic             mode_persist = 1'b0;
  logic [PORTS-1:0] beat_valid = '0, beat_ready = '0, beat_iso = '0, beat_data = '0;
  logic [PORTS-1:0] parity_in = '0;
  logic [PORTS-1:0] parity_out;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;  // 250 MHz

  perr_inject_ctrl #(.PORTS(PORTS)) u0 (
    .clk(clk), .rst(rst), .csr_wr_en(csr_wr_en), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .mode_persist(mode_persist),
    .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_iso(beat_iso),
    .beat_data(beat_data), .parity_in(parity_in), .parity_out(parity_out)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic csr_wr(input logic [31:0] d);
    csr_wr_en = 1'b1;
    csr_wdata = d;
    tick();
    csr_wr_en = 1'b0;
  endtask

  // present one beat of kind k on port p; check parity one edge later
  task automatic beat(input int p, input int k, input logic rdy, input logic par,
                      input logic exp_flip, input string req);
    beat_valid[p] = 1'b1;
    beat_ready[p] = rdy;
    beat_iso[p]   = ~k[1];
    beat_data[p]  = k[0];
    parity_in[p]  = par;
    tick();
    chk(req, {31'd0, parity_out[p]}, {31'd0, par ^ exp_flip});
    beat_valid = '0;
    beat_ready = '0;
  endtask

  function automatic logic [31:0] en_bit(input int p, input int k);
    return 32'd1 << (k*PORTS + p);
  endfunction

  function automatic logic [31:0] done_bit(input int p, input int k);
    return 32'd1 << (16 + k*PORTS + p);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired (all requirements)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] e;
    logic [31:0] d;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    chk("R1 register after reset", csr_rdata, 32'd0);
    chk("R1 parity after reset", {28'd0, parity_out}, 32'd0);

    // R2: read back
    csr_wr(32'hA5C3_3C5A);
    chk("R2 readback", csr_rdata, 32'hA5C3_3C5A);
    csr_wr(32'h0);
    chk("R2 readback zero", csr_rdata, 32'd0);

    // sweep: both modes, every port, every kind
    for (int m = 0; m < 2; m++) begin
      for (int p = 0; p < PORTS; p++) begin
        for (int k = 0; k < 4; k++) begin
          mode_persist = m[0];
          e = en_bit(p, k);
          d = done_bit(p, k);
          csr_wr(32'h0);
          csr_wr(e);
          for (int t = 0; t < 4; t++)
            if (t != k) beat(p, t, 1'b1, t[0], 1'b0, "R3 other kind passes/R4");
          beat(p, k, 1'b0, 1'b1, 1'b0, "R3 not ready passes");
          beat((p + 1) % PORTS, k, 1'b1, 1'b1, 1'b0, "R3 other port passes");
          beat(p, k, 1'b1, 1'b1, 1'b1, m ? "R7 first beat flipped/R4" : "R5 first beat flipped/R4");
          chk(m ? "R7 done set" : "R5 done set", csr_rdata, e | d);
          beat(p, k, 1'b1, 1'b0, m[0], m ? "R7 second beat flipped" : "R6 second beat passes");
        end
      end
    end

    // directed single-shot cases on port 2, isochronous data
    mode_persist = 1'b0;
    e = en_bit(2, 1);
    d = done_bit(2, 1);
    csr_wr(32'h0);
    csr_wr(e);
    beat(2, 1, 1'b1, 1'b0, 1'b1, "R5 beat right after write");
    csr_wr(e);                  // clear done only
    beat(2, 1, 1'b1, 1'b0, 1'b0, "R6 clearing done only does not arm");
    csr_wr(d);                  // enable off, done on
    csr_wr(e | d);              // enable rises with done still set
    beat(2, 1, 1'b1, 1'b1, 1'b0, "R6 enable with done set does not arm");
    csr_wr(32'h0);
    csr_wr(e);
    beat(2, 1, 1'b1, 1'b1, 1'b1, "R6 rearm after clearing both");

    // R8: write clearing done in the cycle the injection fires
    csr_wr(32'h0);
    csr_wr(e);
    csr_wr_en = 1'b1;
    csr_wdata = e;
    beat(2, 1, 1'b1, 1'b0, 1'b1, "R8 beat flipped during write");
    csr_wr_en = 1'b0;
    chk("R8 hardware done wins", csr_rdata, e | d);

    // R9: mode change on best-effort command, port 0
    e = en_bit(0, 2);
    csr_wr(32'h0);
    mode_persist = 1'b1;
    csr_wr(e);
    beat(0, 2, 1'b1, 1'b0, 1'b1, "R9 persistent beat 1");
    beat(0, 2, 1'b1, 1'b1, 1'b1, "R9 persistent beat 2");
    mode_persist = 1'b0;
    beat(0, 2, 1'b1, 1'b1, 1'b0, "R9 switched to single-shot passes");
    mode_persist = 1'b1;
    beat(0, 2, 1'b1, 1'b0, 1'b1, "R9 switched back to persistent flips");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule